// File: doc/BRIEF.md
# DMA Controller Configuration Register Bank

This block holds the software-visible configuration of a multi-channel DMA controller with a built-in CRC engine. It provides a word-addressed write and read port with a single write strobe and no byte lanes. It passes the stored fields to the transfer engine, the arbiter and the CRC datapath. Those consumers are not part of this block. Only their enable bits and their configuration are stored here.

Writes are filtered against the live enable state. Address-pointer registers are frozen while the DMA core runs. CRC setup is frozen while the CRC unit runs. Most of a channel's trigger setup is frozen while that channel runs, but its command and priority fields stay writable. Channel registers are reached indirectly: a selector register chooses which of the channel banks the two channel addresses reach.

Two software-reset bits return registers to zero. One clears the whole bank. The other clears only the currently selected channel. Each is honoured only when the relevant engines are idle.

Top module: `dma_cfg_regs`

## Requirements
- R1: While `rst_n` is low, every exported field and every readable register is zero.
- R2: The descriptor pointer (address 1) and the write-back pointer (address 2) take a write only when `dma_en` is 0. Otherwise they keep their value.
- R3: A write to address 0 with bit 0 set, made while `dma_en` and `crc_en` are both 0, clears at that clock edge:
    - every global and CRC register,
    - the channel selector,
    - every channel bank.
  The other bits of that write are discarded. When either enable is 1, bit 0 is ignored and the remaining bits of the write still apply.
- R4: The CRC setup register (address 3) and the CRC seed/checksum register (address 4) take a write only when `crc_en` is 0. The CRC setup register has these fields: beat size in bits 1:0, polynomial in bits 3:2, input source in bits 9:4.
- R5: Bits 1:0 of address 5 select a channel. Reads and writes at address 6 and address 7 reach only the selected channel's bank.
- R6: In the trigger register (address 7), the following fields take a write only while the selected channel's enable is 0:
    - trigger action, bits 1:0,
    - trigger source, bits 7:2.
  The following fields take every write:
    - priority level, bits 9:8,
    - command, bits 11:10.
- R7: A write to address 6 with bit 0 set clears the selected channel's bank if that channel's enable is 0, and leaves every other bank unchanged. If the channel's enable is 1, bit 0 is ignored.
- R8: These enable bits accept every write:
    - `dma_en`, address 0 bit 1,
    - `crc_en`, address 0 bit 2,
    - the per-level arbiter enables, address 0 bits 11:8, each set independently,
    - a channel's enable, address 6 bit 1.
- R9: A single write that sets an enable together with a software-reset bit is judged against the enable value held before that write.
- R10: Read data is combinational from `bus_addr`. Software-reset bits always read as 0, and addresses 8 to 15 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Word address for read and write |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| dma_en | output | 1 | DMA core enable |
| crc_en | output | 1 | CRC unit enable |
| lvl_en | output | N_LVL | Arbiter priority-level enables |
| desc_base | output | 32 | Descriptor memory pointer |
| wb_base | output | 32 | Write-back memory pointer |
| crc_beat | output | 2 | CRC beat size |
| crc_poly | output | 2 | CRC polynomial type |
| crc_src | output | 6 | CRC input source |
| crc_sum | output | 32 | CRC seed/checksum |
| ch_en | output | N_CH | Channel enables |
| ch_tact | output | N_CH*2 | Trigger action per channel |
| ch_tsrc | output | N_CH*6 | Trigger source per channel |
| ch_prio | output | N_CH*2 | Priority level per channel |
| ch_cmd | output | N_CH*2 | Command per channel |

## Verification
The bench targets the partial lock in the trigger register. A design that froze the whole register would lose the command and priority update. A design that froze nothing would let the trigger fields change on a running channel.

It also tests software resets issued while engines are running, and combined enable-plus-reset writes. A design that judged these against the new enable would either clear a running block or refuse a legal reset.

Indirection is checked by writing one channel and reading a neighbour. A channel reset is checked by confirming that the other banks survive. A design that decoded the selector wrongly or cleared all banks would show stale or missing values there.

// File: rtl/dma_cfg_pkg.sv
// Package: shared constants, field positions and types for the DMA configuration bank.
// Assumes word addressing with a 4-bit address and 32-bit data.
package dma_cfg_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;

    // Channel field widths
    localparam int TACT_W = 2;
    localparam int TSRC_W = 6;
    localparam int PRIO_W = 2;
    localparam int CMD_W  = 2;

    // CRC field widths
    localparam int CBEAT_W = 2;
    localparam int CPOLY_W = 2;
    localparam int CSRC_W  = 6;

    // Register addresses
    localparam logic [ADDR_W-1:0] A_GCTRL  = 4'd0;
    localparam logic [ADDR_W-1:0] A_DESC   = 4'd1;
    localparam logic [ADDR_W-1:0] A_WBACK  = 4'd2;
    localparam logic [ADDR_W-1:0] A_CRCCTL = 4'd3;
    localparam logic [ADDR_W-1:0] A_CRCSUM = 4'd4;
    localparam logic [ADDR_W-1:0] A_CHSEL  = 4'd5;
    localparam logic [ADDR_W-1:0] A_CHCTLA = 4'd6;
    localparam logic [ADDR_W-1:0] A_CHCTLB = 4'd7;

    // Global control bits
    localparam int G_SRST    = 0;
    localparam int G_DMAEN   = 1;
    localparam int G_CRCEN   = 2;
    localparam int G_LVL_LSB = 8;

    // Channel control A bits
    localparam int CA_SRST = 0;
    localparam int CA_EN   = 1;

    // Channel control B field positions
    localparam int B_TACT_LSB = 0;
    localparam int B_TSRC_LSB = B_TACT_LSB + TACT_W;
    localparam int B_PRIO_LSB = B_TSRC_LSB + TSRC_W;
    localparam int B_CMD_LSB  = B_PRIO_LSB + PRIO_W;
    localparam int CHB_W      = B_CMD_LSB + CMD_W;

    typedef struct packed {
        logic              en;
        logic [CMD_W-1:0]  cmd;
        logic [PRIO_W-1:0] prio;
        logic [TSRC_W-1:0] tsrc;
        logic [TACT_W-1:0] tact;
    } chan_cfg_t;

    typedef struct packed {
        logic [CSRC_W-1:0]  src;
        logic [CPOLY_W-1:0] poly;
        logic [CBEAT_W-1:0] beat;
    } crc_cfg_t;

    localparam int CRC_CFG_W = $bits(crc_cfg_t);
endpackage

// File: rtl/dma_cfg_global.sv
// Module: global, CRC and channel-selector registers.
// Produces glob_clr, the qualified global software reset, which the channel
// banks use as a same-edge clear. Protection is judged on the held enables.
module dma_cfg_global
    import dma_cfg_pkg::*;
#(
    parameter int N_LVL = 4,
    parameter int CH_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              glob_clr,
    output logic              dma_en,
    output logic              crc_en,
    output logic [N_LVL-1:0]  lvl_en,
    output logic [DATA_W-1:0] desc_base,
    output logic [DATA_W-1:0] wb_base,
    output crc_cfg_t          crc_cfg,
    output logic [DATA_W-1:0] crc_sum,
    output logic [CH_W-1:0]   ch_sel
);
    logic wr_g;
    logic wr_desc;
    logic wr_wb;
    logic wr_cctl;
    logic wr_csum;
    logic wr_sel;

    // Decode each register's write and apply its lock
    always_comb begin
        wr_g    = wr_en && (wr_addr == A_GCTRL);
        wr_desc = wr_en && (wr_addr == A_DESC)   && !dma_en;
        wr_wb   = wr_en && (wr_addr == A_WBACK)  && !dma_en;
        wr_cctl = wr_en && (wr_addr == A_CRCCTL) && !crc_en;
        wr_csum = wr_en && (wr_addr == A_CRCSUM) && !crc_en;
        wr_sel  = wr_en && (wr_addr == A_CHSEL);
    end

    // Qualify global reset against enables held before this write
    assign glob_clr = wr_g && wr_data[G_SRST] && !dma_en && !crc_en;

    // Global enables and priority-level enables
    always_ff @(posedge clk) begin
        if (!rst_n || glob_clr) begin
            dma_en <= 1'b0;
            crc_en <= 1'b0;
            lvl_en <= '0;
        end else if (wr_g) begin
            dma_en <= wr_data[G_DMAEN];
            crc_en <= wr_data[G_CRCEN];
            lvl_en <= wr_data[G_LVL_LSB +: N_LVL];
        end
    end

    // Descriptor and write-back pointers, locked while DMA runs
    always_ff @(posedge clk) begin
        if (!rst_n || glob_clr) begin
            desc_base <= '0;
            wb_base   <= '0;
        end else begin
            if (wr_desc) desc_base <= wr_data;
            if (wr_wb)   wb_base   <= wr_data;
        end
    end

    // CRC setup and checksum, locked while CRC runs
    always_ff @(posedge clk) begin
        if (!rst_n || glob_clr) begin
            crc_cfg <= '0;
            crc_sum <= '0;
        end else begin
            if (wr_cctl) crc_cfg <= crc_cfg_t'(wr_data[CRC_CFG_W-1:0]);
            if (wr_csum) crc_sum <= wr_data;
        end
    end

    // Channel selector for indirect bank access
    always_ff @(posedge clk) begin
        if (!rst_n || glob_clr) begin
            ch_sel <= '0;
        end else if (wr_sel) begin
            ch_sel <= wr_data[CH_W-1:0];
        end
    end
endmodule

// File: rtl/dma_cfg_chan.sv
// Module: one channel's register bank.
// Assumes bank_sel is high only for the channel the selector points at.
// Trigger fields are locked while enabled; command and priority are not.
module dma_cfg_chan
    import dma_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              glob_clr,
    input  logic              bank_sel,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CHB_W-1:0]  wr_data,
    output chan_cfg_t         cfg
);
    logic wr_a;
    logic wr_b;
    logic ch_clr;

    // Decode writes aimed at this bank
    always_comb begin
        wr_a   = wr_en && bank_sel && (wr_addr == A_CHCTLA);
        wr_b   = wr_en && bank_sel && (wr_addr == A_CHCTLB);
        ch_clr = wr_a && wr_data[CA_SRST] && !cfg.en;
    end

    // Bank state with the partial lock and the local reset
    always_ff @(posedge clk) begin
        if (!rst_n || glob_clr || ch_clr) begin
            cfg <= '0;
        end else begin
            if (wr_a) cfg.en <= wr_data[CA_EN];
            if (wr_b) begin
                cfg.prio <= wr_data[B_PRIO_LSB +: PRIO_W];
                cfg.cmd  <= wr_data[B_CMD_LSB +: CMD_W];
                if (!cfg.en) begin
                    cfg.tact <= wr_data[B_TACT_LSB +: TACT_W];
                    cfg.tsrc <= wr_data[B_TSRC_LSB +: TSRC_W];
                end
            end
        end
    end
endmodule

// File: rtl/dma_cfg_rdmux.sv
// Module: combinational read multiplexer.
// Assumes sel_cfg is already the selected channel's bank. Reset bits read 0.
module dma_cfg_rdmux
    import dma_cfg_pkg::*;
#(
    parameter int N_LVL = 4,
    parameter int CH_W  = 2
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              dma_en,
    input  logic              crc_en,
    input  logic [N_LVL-1:0]  lvl_en,
    input  logic [DATA_W-1:0] desc_base,
    input  logic [DATA_W-1:0] wb_base,
    input  crc_cfg_t          crc_cfg,
    input  logic [DATA_W-1:0] crc_sum,
    input  logic [CH_W-1:0]   ch_sel,
    input  chan_cfg_t         sel_cfg,
    output logic [DATA_W-1:0] rd_data
);
    // Build the read word for the addressed register
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_GCTRL: begin
                rd_data[G_DMAEN]             = dma_en;
                rd_data[G_CRCEN]             = crc_en;
                rd_data[G_LVL_LSB +: N_LVL]  = lvl_en;
            end
            A_DESC:   rd_data = desc_base;
            A_WBACK:  rd_data = wb_base;
            A_CRCCTL: rd_data[CRC_CFG_W-1:0] = crc_cfg;
            A_CRCSUM: rd_data = crc_sum;
            A_CHSEL:  rd_data[CH_W-1:0] = ch_sel;
            A_CHCTLA: rd_data[CA_EN] = sel_cfg.en;
            A_CHCTLB: begin
                rd_data[B_TACT_LSB +: TACT_W] = sel_cfg.tact;
                rd_data[B_TSRC_LSB +: TSRC_W] = sel_cfg.tsrc;
                rd_data[B_PRIO_LSB +: PRIO_W] = sel_cfg.prio;
                rd_data[B_CMD_LSB +: CMD_W]   = sel_cfg.cmd;
            end
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/dma_cfg_regs.sv
// Module: top of the DMA configuration register bank.
// Connects the global registers, N_CH channel banks and the read mux, and
// flattens the configuration onto plain output vectors. Reset is synchronous.
module dma_cfg_regs
    import dma_cfg_pkg::*;
#(
    parameter int N_CH  = 4,
    parameter int N_LVL = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     bus_wr,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic [DATA_W-1:0]        bus_rdata,
    output logic                     dma_en,
    output logic                     crc_en,
    output logic [N_LVL-1:0]         lvl_en,
    output logic [DATA_W-1:0]        desc_base,
    output logic [DATA_W-1:0]        wb_base,
    output logic [CBEAT_W-1:0]       crc_beat,
    output logic [CPOLY_W-1:0]       crc_poly,
    output logic [CSRC_W-1:0]        crc_src,
    output logic [DATA_W-1:0]        crc_sum,
    output logic [N_CH-1:0]          ch_en,
    output logic [N_CH*TACT_W-1:0]   ch_tact,
    output logic [N_CH*TSRC_W-1:0]   ch_tsrc,
    output logic [N_CH*PRIO_W-1:0]   ch_prio,
    output logic [N_CH*CMD_W-1:0]    ch_cmd
);
    localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1;

    logic            glob_clr;
    logic [CH_W-1:0] ch_sel;
    crc_cfg_t        crc_cfg;
    chan_cfg_t       bank [N_CH];
    chan_cfg_t       sel_cfg;

    dma_cfg_global #(.N_LVL(N_LVL), .CH_W(CH_W)) u_global (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr),
        .wr_addr   (bus_addr),
        .wr_data   (bus_wdata),
        .glob_clr  (glob_clr),
        .dma_en    (dma_en),
        .crc_en    (crc_en),
        .lvl_en    (lvl_en),
        .desc_base (desc_base),
        .wb_base   (wb_base),
        .crc_cfg   (crc_cfg),
        .crc_sum   (crc_sum),
        .ch_sel    (ch_sel)
    );

    assign crc_beat = crc_cfg.beat;
    assign crc_poly = crc_cfg.poly;
    assign crc_src  = crc_cfg.src;

    for (genvar g = 0; g < N_CH; g++) begin : g_bank
        dma_cfg_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .glob_clr (glob_clr),
            .bank_sel (ch_sel == CH_W'(g)),
            .wr_en    (bus_wr),
            .wr_addr  (bus_addr),
            .wr_data  (bus_wdata[CHB_W-1:0]),
            .cfg      (bank[g])
        );
        assign ch_en[g]                       = bank[g].en;
        assign ch_tact[g*TACT_W +: TACT_W]    = bank[g].tact;
        assign ch_tsrc[g*TSRC_W +: TSRC_W]    = bank[g].tsrc;
        assign ch_prio[g*PRIO_W +: PRIO_W]    = bank[g].prio;
        assign ch_cmd[g*CMD_W +: CMD_W]       = bank[g].cmd;
    end

    // Pick the selected bank for read-back
    always_comb begin
        sel_cfg = '0;
        for (int i = 0; i < N_CH; i++) begin
            if (ch_sel == CH_W'(i)) sel_cfg = bank[i];
        end
    end

    dma_cfg_rdmux #(.N_LVL(N_LVL), .CH_W(CH_W)) u_rdmux (
        .rd_addr   (bus_addr),
        .dma_en    (dma_en),
        .crc_en    (crc_en),
        .lvl_en    (lvl_en),
        .desc_base (desc_base),
        .wb_base   (wb_base),
        .crc_cfg   (crc_cfg),
        .crc_sum   (crc_sum),
        .ch_sel    (ch_sel),
        .sel_cfg   (sel_cfg),
        .rd_data   (bus_rdata)
    );
endmodule

// File: rtl/dma_cfg_regs_chk.sv
// Module: property checker bound to dma_cfg_regs.
// Assumes it observes the top's ports and its internal glob_clr.
module dma_cfg_regs_chk
    import dma_cfg_pkg::*;
#(
    parameter int N_CH = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   glob_clr,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic                   rd_bit0,
    input logic                   dma_en,
    input logic                   crc_en,
    input logic [DATA_W-1:0]      desc_base,
    input logic [DATA_W-1:0]      wb_base,
    input logic [CBEAT_W-1:0]     crc_beat,
    input logic [CPOLY_W-1:0]     crc_poly,
    input logic [CSRC_W-1:0]      crc_src,
    input logic [DATA_W-1:0]      crc_sum,
    input logic [N_CH-1:0]        ch_en,
    input logic [N_CH*TACT_W-1:0] ch_tact,
    input logic [N_CH*TSRC_W-1:0] ch_tsrc
);
    // R2: pointers hold while the DMA core runs
    a_r2_base_locked: assert property (@(posedge clk) disable iff (!rst_n)
        dma_en |=> ($stable(desc_base) && $stable(wb_base)));

    // R4: CRC setup and checksum hold while CRC runs
    a_r4_crc_locked: assert property (@(posedge clk) disable iff (!rst_n)
        crc_en |=> ($stable(crc_beat) && $stable(crc_poly) && $stable(crc_src) && $stable(crc_sum)));

    // R3: a qualified global reset leaves everything cleared
    a_r3_glob_clear: assert property (@(posedge clk) disable iff (!rst_n)
        glob_clr |=> (!dma_en && !crc_en && desc_base == '0 && wb_base == '0
                      && crc_sum == '0 && ch_en == '0));

    // R3: a global reset is only honoured with both engines idle
    a_r3_clr_idle: assert property (@(posedge clk) disable iff (!rst_n)
        glob_clr |-> (!dma_en && !crc_en));

    // R10: the global reset bit always reads as zero
    a_r10_srst_reads0: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_GCTRL) |-> !rd_bit0);

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        // R6: trigger fields hold while the channel runs
        a_r6_trig_locked: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_en[i] && !glob_clr) |=>
            ($stable(ch_tact[i*TACT_W +: TACT_W]) && $stable(ch_tsrc[i*TSRC_W +: TSRC_W])));
    end
endmodule

bind dma_cfg_regs dma_cfg_regs_chk #(.N_CH(N_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .glob_clr  (glob_clr),
    .bus_addr  (bus_addr),
    .rd_bit0   (bus_rdata[0]),
    .dma_en    (dma_en),
    .crc_en    (crc_en),
    .desc_base (desc_base),
    .wb_base   (wb_base),
    .crc_beat  (crc_beat),
    .crc_poly  (crc_poly),
    .crc_src   (crc_src),
    .crc_sum   (crc_sum),
    .ch_en     (ch_en),
    .ch_tact   (ch_tact),
    .ch_tsrc   (ch_tsrc)
);

// File: tb/dma_cfg_regs_bench.sv
// Bench: walks a table of write and read-check steps through the bus port,
// then runs directed checks on the exported fields and on reset.
module dma_cfg_regs_bench;
    localparam int N_CH  = 4;
    localparam int N_LVL = 4;
    localparam int NV    = 64;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [3:0]           bus_addr = '0;
    logic                 bus_wr = 1'b0;
    logic [31:0]          bus_wdata = '0;
    logic [31:0]          bus_rdata;
    logic                 dma_en, crc_en;
    logic [N_LVL-1:0]     lvl_en;
    logic [31:0]          desc_base, wb_base, crc_sum;
    logic [1:0]           crc_beat, crc_poly;
    logic [5:0]           crc_src;
    logic [N_CH-1:0]      ch_en;
    logic [N_CH*2-1:0]    ch_tact, ch_prio, ch_cmd;
    logic [N_CH*6-1:0]    ch_tsrc;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dma_cfg_regs #(.N_CH(N_CH), .N_LVL(N_LVL)) u_dma_cfg_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dma_en(dma_en),
        .crc_en(crc_en), .lvl_en(lvl_en), .desc_base(desc_base),
        .wb_base(wb_base), .crc_beat(crc_beat), .crc_poly(crc_poly),
        .crc_src(crc_src), .crc_sum(crc_sum), .ch_en(ch_en),
        .ch_tact(ch_tact), .ch_tsrc(ch_tsrc), .ch_prio(ch_prio), .ch_cmd(ch_cmd)
    );

    typedef struct packed {
        logic        wr;
        logic [3:0]  addr;
        logic [31:0] data;
        logic [7:0]  req;
    } step_t;

    // Writes carry data; reads carry the expected value
    localparam step_t TBL [NV] = '{
        '{1'b0, 4'h0, 32'h0,        8'd1},  // R1 reset value
        '{1'b1, 4'h1, 32'h20001000, 8'd0},
        '{1'b1, 4'h2, 32'h20002000, 8'd0},
        '{1'b0, 4'h1, 32'h20001000, 8'd2},  // R2
        '{1'b0, 4'h2, 32'h20002000, 8'd2},  // R2
        '{1'b1, 4'h0, 32'h00000502, 8'd0},
        '{1'b0, 4'h0, 32'h00000502, 8'd8},  // R8 dma_en + levels 0,2
        '{1'b1, 4'h1, 32'hDEADBEEF, 8'd0},
        '{1'b0, 4'h1, 32'h20001000, 8'd2},  // R2 locked
        '{1'b1, 4'h2, 32'h00000001, 8'd0},
        '{1'b0, 4'h2, 32'h20002000, 8'd2},  // R2 locked
        '{1'b1, 4'h3, 32'h000003A5, 8'd0},
        '{1'b1, 4'h4, 32'hCAFEF00D, 8'd0},
        '{1'b0, 4'h3, 32'h000003A5, 8'd4},  // R4
        '{1'b0, 4'h4, 32'hCAFEF00D, 8'd4},  // R4
        '{1'b1, 4'h0, 32'h00000506, 8'd0},
        '{1'b1, 4'h3, 32'h000000F0, 8'd0},
        '{1'b0, 4'h3, 32'h000003A5, 8'd4},  // R4 locked
        '{1'b1, 4'h4, 32'h00000000, 8'd0},
        '{1'b0, 4'h4, 32'hCAFEF00D, 8'd4},  // R4 locked
        '{1'b1, 4'h0, 32'h00000507, 8'd0},
        '{1'b0, 4'h0, 32'h00000506, 8'd3},  // R3 reset refused
        '{1'b0, 4'h1, 32'h20001000, 8'd3},  // R3
        '{1'b1, 4'h5, 32'h00000002, 8'd0},
        '{1'b0, 4'h5, 32'h00000002, 8'd5},  // R5
        '{1'b1, 4'h7, 32'h00000ABC, 8'd0},
        '{1'b0, 4'h7, 32'h00000ABC, 8'd5},  // R5
        '{1'b1, 4'h5, 32'h00000001, 8'd0},
        '{1'b0, 4'h7, 32'h00000000, 8'd5},  // R5 other bank
        '{1'b1, 4'h7, 32'h00000123, 8'd0},
        '{1'b0, 4'h7, 32'h00000123, 8'd5},  // R5
        '{1'b1, 4'h6, 32'h00000002, 8'd0},
        '{1'b0, 4'h6, 32'h00000002, 8'd8},  // R8
        '{1'b1, 4'h7, 32'h00000FFF, 8'd0},
        '{1'b0, 4'h7, 32'h00000F23, 8'd6},  // R6 partial lock
        '{1'b1, 4'h6, 32'h00000003, 8'd0},
        '{1'b0, 4'h6, 32'h00000002, 8'd7},  // R7 reset refused
        '{1'b0, 4'h7, 32'h00000F23, 8'd7},  // R7
        '{1'b1, 4'h5, 32'h00000002, 8'd0},
        '{1'b1, 4'h6, 32'h00000001, 8'd0},
        '{1'b0, 4'h7, 32'h00000000, 8'd7},  // R7 bank 2 cleared
        '{1'b1, 4'h5, 32'h00000001, 8'd0},
        '{1'b0, 4'h7, 32'h00000F23, 8'd7},  // R7 bank 1 kept
        '{1'b1, 4'h6, 32'h00000000, 8'd0},
        '{1'b1, 4'h7, 32'h000000AA, 8'd0},
        '{1'b0, 4'h7, 32'h000000AA, 8'd6},  // R6 unlocked
        '{1'b1, 4'h0, 32'h00000000, 8'd0},
        '{1'b0, 4'h0, 32'h00000000, 8'd8},  // R8
        '{1'b1, 4'h5, 32'h00000003, 8'd0},
        '{1'b1, 4'h6, 32'h00000003, 8'd0},
        '{1'b0, 4'h6, 32'h00000000, 8'd9},  // R9 reset beats new enable
        '{1'b1, 4'h7, 32'h00000055, 8'd0},
        '{1'b1, 4'h6, 32'h00000002, 8'd0},
        '{1'b0, 4'h6, 32'h00000002, 8'd8},  // R8
        '{1'b1, 4'h0, 32'h00000F03, 8'd0},
        '{1'b0, 4'h0, 32'h00000000, 8'd9},  // R9
        '{1'b0, 4'h1, 32'h00000000, 8'd3},  // R3
        '{1'b0, 4'h4, 32'h00000000, 8'd3},  // R3
        '{1'b0, 4'h5, 32'h00000000, 8'd3},  // R3
        '{1'b1, 4'h5, 32'h00000001, 8'd0},
        '{1'b0, 4'h7, 32'h00000000, 8'd3},  // R3
        '{1'b1, 4'h5, 32'h00000003, 8'd0},
        '{1'b0, 4'h6, 32'h00000000, 8'd3},  // R3
        '{1'b0, 4'hC, 32'h00000000, 8'd10}  // R10 unmapped
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input int req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_check(input logic [3:0] a, input logic [31:0] exp, input int req);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(bus_rdata, exp, req);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < NV; k++) begin
            if (TBL[k].wr) bus_write(TBL[k].addr, TBL[k].data);
            else           bus_check(TBL[k].addr, TBL[k].data, int'(TBL[k].req));
        end

        // R5: exported trigger source of the selected bank only
        bus_write(4'h5, 32'h0);
        bus_write(4'h7, 32'h000000FC);
        @(negedge clk);
        check(32'(ch_tsrc), 32'h0000003F, 5);
        check(32'(ch_tact), 32'h0, 5);

        // R8: enables reach the ports, single level bit alone
        bus_write(4'h0, 32'h00000106);
        @(negedge clk);
        check({29'h0, dma_en, crc_en, 1'b0}, 32'h6, 8);
        check(32'(lvl_en), 32'h1, 8);

        // R1: synchronous reset clears everything
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check({30'h0, dma_en, crc_en}, 32'h0, 1);
        check(32'(ch_tsrc), 32'h0, 1);
        check(32'(lvl_en), 32'h0, 1);
        bus_check(4'h5, 32'h0, 1);
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule